// File: doc/BRIEF.md
# Eight-Channel Thermal Shutdown Controller

This block holds the protection state for eight high-side output channels. Each cycle it takes the commanded on/off state of every channel, an overload flag per channel, a junction temperature code per channel and one temperature code for the shared case. From these it produces the gated enable that actually drives each channel and one common active-low fault signal.

Each channel runs its own small state machine. A channel whose junction runs too hot is switched off and comes back by itself once its junction has cooled past a lower resume point, so the gap between the two points gives hysteresis. When the case also overheats while an overloaded channel is already off for junction heat, that channel is held off more firmly: it resumes only when both its own junction and the case have cooled below their resume points. Channels that are running, or that are not overloaded, are not touched by the case temperature. Commanding a channel off clears its protection state; the junction flag that feeds the fault output keeps being evaluated regardless of the command.

Top module: `thermal_guard`

## Requirements
- R1: While `rst` is high, and in the cycle after the reset edge, every bit of `ch_en` is 0 and `fault_n` is 1.
- R2: All outputs are registered: `ch_en` and `fault_n` reflect the inputs sampled at the previous rising clock edge, one cycle of latency; a channel commanded on with no thermal condition is enabled after that cycle.
- R3: Channel i's junction code is `tj_code[i*8 +: 8]`, unsigned in degrees. A code strictly above `TJ_TRIP` (default 170) disables that channel on the next cycle; a code equal to `TJ_TRIP` does not.
- R4: A channel off for junction heat, and not held by the case, re-enables once its junction code is strictly below `TJ_RESUME` (default 150); codes from `TJ_RESUME` up to `TJ_TRIP` keep it off.
- R5: If a channel is off for junction heat, its overload flag is 1 and `tc_code` is strictly above `TC_TRIP` (default 130), it becomes held; a held channel re-enables only when its junction code is below `TJ_RESUME` and `tc_code` is strictly below `TC_RESUME` (default 110) in the same cycle.
- R6: Case temperature has no effect on a running channel, and a channel off for junction heat whose overload flag is 0 restarts on junction cooling alone even with the case hot.
- R7: A channel with `cmd_on` 0 has `ch_en` 0 on the next cycle and its shutdown or held state is cleared, so a later command on re-enables it unless its junction code is above `TJ_TRIP`.
- R8: Each channel keeps a junction flag, set when its code exceeds `TJ_TRIP` and cleared when it falls below `TJ_RESUME`, evaluated whatever the command; `fault_n` is 0 exactly when at least one flag is set, and it is not latched.
- R9: Each channel's state depends only on its own command, overload flag and junction code plus the shared case code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_on | input | 8 | Commanded state per channel, 1 = on |
| ovld | input | 8 | Overload flag per channel from the current limiter |
| tj_code | input | 64 | Junction temperature codes, channel i in bits i*8+7..i*8 |
| tc_code | input | 8 | Case temperature code |
| ch_en | output | 8 | Gated enable per channel, registered |
| fault_n | output | 1 | Common thermal fault, active low, registered |

## Verification
The assertions check on every cycle that an over-threshold junction turns its channel off, that a channel commanded off stays disabled, that a running channel without junction heat is kept running whatever the case does, that a held overloaded channel stays off while the case is hot, and that the fault output follows the junction thresholds. Hysteresis band behaviour, the exact release condition of a held channel, the clearing of state by a command off and independence between channels need multi-step histories, so only the bench's directed sequences and its randomized runs against a reference model can show them.

// File: rtl/thermal_guard_pkg.sv
package thermal_guard_pkg;

  typedef enum logic [1:0] {
    CH_RUN    = 2'd0,
    CH_JOFF   = 2'd1,
    CH_HELD   = 2'd2
  } chan_st_e;

  typedef struct packed {
    logic hot;
    logic cool;
  } zone_t;

endpackage

// File: rtl/tg_zone_cmp.sv
module tg_zone_cmp
  import thermal_guard_pkg::*;
#(
  parameter int TW     = 8,
  parameter int TRIP   = 170,
  parameter int RESUME = 150
) (
  input  logic [TW-1:0] code,
  output zone_t         zone
);

  localparam logic [TW-1:0] TRIP_C   = TW'(TRIP);
  localparam logic [TW-1:0] RESUME_C = TW'(RESUME);

  always_comb begin
    zone.hot  = (code > TRIP_C);
    zone.cool = (code < RESUME_C);
  end

endmodule

// File: rtl/tg_chan_fsm.sv
module tg_chan_fsm
  import thermal_guard_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  cmd,
  input  logic  ovl,
  input  zone_t jz,
  input  zone_t cz,
  output logic  en_q,
  output logic  jflag_d
);

  chan_st_e st_q, st_d;
  logic     jflag_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      CH_RUN:  if (jz.hot) st_d = CH_JOFF;
      CH_JOFF: begin
        if (cz.hot && ovl)  st_d = CH_HELD;
        else if (jz.cool)   st_d = CH_RUN;
      end
      CH_HELD: if (jz.cool && cz.cool) st_d = CH_RUN;
      default: st_d = CH_RUN;
    endcase
    if (!cmd) st_d = CH_RUN;
  end

  always_comb begin
    if (jz.hot)       jflag_d = 1'b1;
    else if (jz.cool) jflag_d = 1'b0;
    else              jflag_d = jflag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= CH_RUN;
      en_q    <= 1'b0;
      jflag_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      en_q    <= cmd && (st_d == CH_RUN);
      jflag_q <= jflag_d;
    end
  end

endmodule

// File: rtl/tg_fault_or.sv
module tg_fault_or #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] flags_d,
  output logic           fault_n
);

  always_ff @(posedge clk) begin
    if (rst) fault_n <= 1'b1;
    else     fault_n <= ~(|flags_d);
  end

endmodule

// File: rtl/thermal_guard.sv
module thermal_guard
  import thermal_guard_pkg::*;
#(
  parameter int NCH       = 8,
  parameter int TW        = 8,
  parameter int TJ_TRIP   = 170,
  parameter int TJ_RESUME = 150,
  parameter int TC_TRIP   = 130,
  parameter int TC_RESUME = 110
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    cmd_on,
  input  logic [NCH-1:0]    ovld,
  input  logic [NCH*TW-1:0] tj_code,
  input  logic [TW-1:0]     tc_code,
  output logic [NCH-1:0]    ch_en,
  output logic              fault_n
);

  zone_t          case_z;
  logic [NCH-1:0] jflag_nxt;

  tg_zone_cmp #(.TW(TW), .TRIP(TC_TRIP), .RESUME(TC_RESUME)) u_case_cmp (
    .code (tc_code),
    .zone (case_z)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    zone_t jz;

    tg_zone_cmp #(.TW(TW), .TRIP(TJ_TRIP), .RESUME(TJ_RESUME)) u_jcmp (
      .code (tj_code[i*TW +: TW]),
      .zone (jz)
    );

    tg_chan_fsm u_fsm (
      .clk     (clk),
      .rst     (rst),
      .cmd     (cmd_on[i]),
      .ovl     (ovld[i]),
      .jz      (jz),
      .cz      (case_z),
      .en_q    (ch_en[i]),
      .jflag_d (jflag_nxt[i])
    );
  end

  tg_fault_or #(.NCH(NCH)) u_fault (
    .clk     (clk),
    .rst     (rst),
    .flags_d (jflag_nxt),
    .fault_n (fault_n)
  );

endmodule

// File: rtl/thermal_guard_chk.sv
module thermal_guard_chk #(
  parameter int NCH       = 8,
  parameter int TW        = 8,
  parameter int TJ_TRIP   = 170,
  parameter int TJ_RESUME = 150,
  parameter int TC_TRIP   = 130,
  parameter int TC_RESUME = 110
) (
  input logic              clk,
  input logic              rst,
  input logic [NCH-1:0]    cmd_on,
  input logic [NCH-1:0]    ovld,
  input logic [NCH*TW-1:0] tj_code,
  input logic [TW-1:0]     tc_code,
  input logic [NCH-1:0]    ch_en,
  input logic              fault_n
);

  localparam logic [TW-1:0] JT = TW'(TJ_TRIP);
  localparam logic [TW-1:0] JR = TW'(TJ_RESUME);
  localparam logic [TW-1:0] CT = TW'(TC_TRIP);

  logic [NCH-1:0] hot_v, cool_v;
  logic           case_hot;

  assign case_hot = (tc_code > CT);

  for (genvar i = 0; i < NCH; i++) begin : g_a
    assign hot_v[i]  = (tj_code[i*TW +: TW] > JT);
    assign cool_v[i] = (tj_code[i*TW +: TW] < JR);

    assert_trip_off_R3: assert property (@(posedge clk) disable iff (rst)
      hot_v[i] |=> !ch_en[i]);

    assert_cmd_gate_R7: assert property (@(posedge clk) disable iff (rst)
      !cmd_on[i] |=> !ch_en[i]);

    assert_run_keeps_R6: assert property (@(posedge clk) disable iff (rst)
      (ch_en[i] && cmd_on[i] && !hot_v[i]) |=> ch_en[i]);

    assert_held_stays_R5: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(cmd_on[i]) && !ch_en[i] && cmd_on[i] && ovld[i] && case_hot)
      |=> !ch_en[i]);
  end

  assert_fault_set_R8: assert property (@(posedge clk) disable iff (rst)
    (|hot_v) |=> !fault_n);

  assert_fault_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (&cool_v) |=> fault_n);

endmodule

bind thermal_guard thermal_guard_chk #(
  .NCH(NCH), .TW(TW), .TJ_TRIP(TJ_TRIP), .TJ_RESUME(TJ_RESUME),
  .TC_TRIP(TC_TRIP), .TC_RESUME(TC_RESUME)
) u_chk (
  .clk(clk), .rst(rst), .cmd_on(cmd_on), .ovld(ovld), .tj_code(tj_code),
  .tc_code(tc_code), .ch_en(ch_en), .fault_n(fault_n)
);

// File: tb/thermal_guard_bench.sv
module thermal_guard_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [N-1:0]   cmd_on = '0;
  logic [N-1:0]   ovld = '0;
  logic [N*8-1:0] tj_code = '0;
  logic [7:0]     tc_code = '0;
  logic [N-1:0]   ch_en;
  logic           fault_n;

  int total = 0;
  int bad = 0;
  int tjv[N];
  int tcv;
  int mst[N];
  bit mjf[N];
  logic [N-1:0] exp_en;
  logic         exp_fn;

  always #(CLK_PERIOD/2) clk = ~clk;

  thermal_guard u_thermal_guard (
    .clk(clk), .rst(rst), .cmd_on(cmd_on), .ovld(ovld), .tj_code(tj_code),
    .tc_code(tc_code), .ch_en(ch_en), .fault_n(fault_n)
  );

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  task automatic chk_en(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s ch_en act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic chk_fn(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s fault_n act=%b exp=%b", tag, act, exp);
    end
  endtask

  // reference model: one edge with current inputs
  task automatic model_edge();
    logic anyf = 1'b0;
    for (int i = 0; i < N; i++) begin
      bit jh = tjv[i] > 170;
      bit jc = tjv[i] < 150;
      bit chot = tcv > 130;
      bit ccool = tcv < 110;
      int ns = mst[i];
      case (mst[i])
        0: if (jh) ns = 1;
        1: if (chot && ovld[i]) ns = 2; else if (jc) ns = 0;
        default: if (jc && ccool) ns = 0;
      endcase
      if (!cmd_on[i]) ns = 0;
      mst[i] = ns;
      exp_en[i] = cmd_on[i] && (ns == 0);
      if (jh) mjf[i] = 1'b1; else if (jc) mjf[i] = 1'b0;
      if (mjf[i]) anyf = 1'b1;
    end
    exp_fn = ~anyf;
  endtask

  // drive current arrays, step one edge, check at the next falling edge
  task automatic apply(string tag);
    for (int i = 0; i < N; i++) tj_code[i*8 +: 8] = 8'(tjv[i]);
    tc_code = 8'(tcv);
    model_edge();
    @(negedge clk);
    chk_en(tag, ch_en, exp_en);
    chk_fn(tag, fault_n, exp_fn);
  endtask

  initial begin
    int seed_init;
    seed_init = $urandom(32'd4711);
    for (int i = 0; i < N; i++) begin tjv[i] = 50; mst[i] = 0; mjf[i] = 0; end
    tcv = 40;
    for (int i = 0; i < N; i++) tj_code[i*8 +: 8] = 8'(tjv[i]);
    tc_code = 8'(tcv);
    repeat (3) @(negedge clk);
    chk_en("R1 during reset", ch_en, '0);
    chk_fn("R1 during reset", fault_n, 1'b1);
    cmd_on = '1;
    @(negedge clk);
    rst = 1'b0;
    chk_en("R1 after reset edge", ch_en, '0);
    chk_fn("R1 after reset edge", fault_n, 1'b1);

    apply("R2 all channels on");
    // R3: trip strictly above, boundary at trip value
    tjv[0] = 171; tjv[1] = 170;
    apply("R3 trip ch0, ch1 at boundary stays on");
    apply("R8 fault asserted while ch0 hot");
    // R4: hysteresis band then restart
    tjv[0] = 150; tjv[1] = 50;
    apply("R4 band keeps ch0 off, R8 fault held");
    tjv[0] = 149;
    apply("R4 restart below resume, R8 fault released");
    // R5: held by case
    ovld[2] = 1'b1; tjv[2] = 175;
    apply("R5 ch2 junction off");
    tcv = 131;
    apply("R5 case hot latches ch2, R6 runners keep going");
    tjv[2] = 100; tcv = 120;
    apply("R5 junction cool but case warm keeps ch2 off");
    tjv[2] = 160; tcv = 100;
    apply("R5 case cool but junction warm keeps ch2 off");
    tjv[2] = 100;
    apply("R5 both cool releases ch2");
    // R6: non-overloaded channel ignores the case
    tjv[3] = 175; ovld[3] = 1'b0;
    apply("R6 ch3 junction off");
    tcv = 135;
    apply("R6 ch3 not held by hot case");
    tjv[3] = 120;
    apply("R6 ch3 restarts with case hot");
    tcv = 60;
    // R7: command off clears held state
    ovld[4] = 1'b1; tjv[4] = 175;
    apply("R7 ch4 off");
    tcv = 140;
    apply("R7 ch4 held");
    cmd_on[4] = 1'b0; tjv[4] = 160;
    apply("R7 ch4 commanded off");
    cmd_on[4] = 1'b1;
    apply("R7 ch4 re-enabled, R8 flag still set");
    tjv[4] = 171; cmd_on[4] = 1'b0;
    apply("R8 flag evaluated while commanded off");
    cmd_on[4] = 1'b1; tcv = 60; tjv[4] = 60;
    apply("R7 ch4 back on");
    ovld = '0;

    // randomized run, R9 independence through full model comparison
    for (int cyc = 0; cyc < 4000; cyc++) begin
      for (int i = 0; i < N; i++) begin
        if ($urandom_range(3) == 0) tjv[i] = 100 + $urandom_range(85);
        if ($urandom_range(15) == 0) cmd_on[i] = ~cmd_on[i];
        if ($urandom_range(7) == 0) ovld[i] = ~ovld[i];
      end
      if ($urandom_range(7) == 0) tcv = 95 + $urandom_range(45);
      if (cyc == 2000) begin
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < N; i++) begin mst[i] = 0; mjf[i] = 0; end
        chk_en("R1 mid-run reset", ch_en, '0);
        chk_fn("R1 mid-run reset", fault_n, 1'b1);
      end
      apply("R9 random mix");
    end
    summary();
  end

endmodule